// File: doc/BRIEF.md
# Scatter-Gather Disk DMA Channel

This block is the bus-master DMA channel of a single-channel disk interface. Software builds a table of 16-byte descriptors in memory and programs the table pointer, the ending-status address and the transfer direction. It then sets the start bit. The engine fetches each descriptor and moves its buffer between the device byte stream and memory, packing or unpacking 32-bit words. When the descriptor flagged end-of-list has been fully moved, the engine fills a 32-word ending area with all-ones. Software polls that area to learn that every earlier data write has reached memory.

A halt is a handshake: software sets the stop bit and keeps reading it until the engine clears it. A memory error response aborts the walk and raises an error flag and an interrupt status bit. Interrupt status is write-one-to-clear, and the interrupt enables can only be set.

Top module: `sg_dma_engine`

## Requirements
- R1: Registers sit at byte address index*4. The indices are: timing 0, table pointer low 1, table pointer high 2, current buffer address 3 (read-only), buffer address high 4, device byte count 5 (read-only), memory byte count 6 (read-only), control 7, ending address 8, interrupt status 9, interrupt enable 10. All read 0 after reset. An access with a non-zero address bit 1 or 0 is ignored and reads 0.
- R2: The control bits are start 0x01, stop 0x02, direction 0x04, active 0x08 and error 0x10. The start bit always reads 0.
- R3: A control write with start set is accepted only while the engine is inactive and no stop is pending. While active, a control write changes neither start nor direction.
- R4: A descriptor is 16 bytes. The word at +4 is the buffer address. The word at +12 holds the length in bits 15:0, in whole words, with bits 1:0 ignored, and the end-of-list flag in bit 31. A zero-length descriptor moves no data.
- R5: With direction 1, device bytes are packed little-endian into words and written to ascending addresses. With direction 0, memory words are read and sent to the device lowest byte first.
- R6: The device counter counts bytes moved on the device side. The memory counter adds 4 for each completed data word access. Both clear when a start is accepted.
- R7: After the end-of-list descriptor completes, the engine writes 0xFFFFFFFF to 32 ascending words from the ending address. Active falls only after the last of these writes.
- R8: The stop bit reads 1 until the engine has halted, then clears. The halt takes place at a byte boundary or after the outstanding memory response, and no ending marker is written.
- R9: A memory error response sets the error bit and interrupt status bit 1. It ends the walk with no ending marker. The error bit clears when the next start is accepted.
- R10: Interrupt status bit 0 is set while the device interrupt input is high. Writing ones to the status register clears the matching bits. A set event in the same cycle as a clear wins.
- R11: Writing ones to the enable register sets enable bits and never clears them. The interrupt output is high when any enabled status bit is set.
- R12: The memory port has at most one request outstanding. A request holds its address and type stable until its response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |
| dev_irq_i | input | 1 | Device interrupt event |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rvalid_i | input | 1 | Memory response |
| mem_err_i | input | 1 | Response carries an error |
| mem_rdata_i | input | 32 | Memory read data |
| dev_rx_valid_i | input | 1 | Device byte available |
| dev_rx_data_i | input | 8 | Device byte in |
| dev_rx_ready_o | output | 1 | Engine accepts device byte |
| dev_tx_valid_o | output | 1 | Engine offers device byte |
| dev_tx_data_o | output | 8 | Device byte out |
| dev_tx_ready_i | input | 1 | Device accepts byte |

## Verification
Two events can hit the interrupt status in the same cycle: a clear by a software write of ones, and a new set event. The bench holds the device interrupt input high across a write-one-to-clear of bit 0, then reads the status back and expects bit 0 still set. It then drops the input, repeats the clear and expects the bit to clear. A stop request that arrives while the engine waits on a stalled device byte is also checked: the stop bit must read 1 in the cycle after the write, clear only once active has fallen, and leave the ending area untouched.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH_A, S_FETCH_L, S_RX, S_WR, S_RD, S_TX, S_MARK
  } walk_state_e;

  localparam int unsigned IDX_TIMING  = 0;
  localparam int unsigned IDX_PTR_LO  = 1;
  localparam int unsigned IDX_PTR_HI  = 2;
  localparam int unsigned IDX_ADDR_LO = 3;
  localparam int unsigned IDX_ADDR_HI = 4;
  localparam int unsigned IDX_DEV_CNT = 5;
  localparam int unsigned IDX_MEM_CNT = 6;
  localparam int unsigned IDX_CTRL    = 7;
  localparam int unsigned IDX_END     = 8;
  localparam int unsigned IDX_ISTAT   = 9;
  localparam int unsigned IDX_IEN     = 10;

  localparam int unsigned DESC_BYTES = 16;
endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          active_i,
  input  logic          err_set_i,
  input  logic          dev_irq_i,
  input  logic [31:0]   cur_addr_i,
  input  logic [31:0]   dev_cnt_i,
  input  logic [31:0]   mem_cnt_i,
  output logic          start_o,
  output logic          dir_o,
  output logic          stop_o,
  output logic          err_o,
  output logic [1:0]    istat_o,
  output logic [31:0]   ptr_o,
  output logic [31:0]   end_addr_o,
  output logic          irq_o
);
  localparam int unsigned IW = AW - 2;

  logic [IW-1:0] idx;
  logic          aligned;
  logic [31:0]   timing_q, ptr_hi_q, addr_hi_q;
  logic [1:0]    ien_q;

  assign idx     = addr_i[AW-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  logic wr_ok;
  assign wr_ok = wr_i && aligned;

  function automatic logic hit(input logic [IW-1:0] i, input int unsigned k);
    return i == IW'(k);
  endfunction

  logic wr_ctrl;
  assign wr_ctrl = wr_ok && hit(idx, IDX_CTRL);
  assign start_o = wr_ctrl && wdata_i[0] && !active_i && !stop_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timing_q   <= '0;
      ptr_o      <= '0;
      ptr_hi_q   <= '0;
      addr_hi_q  <= '0;
      end_addr_o <= '0;
      dir_o      <= 1'b0;
      stop_o     <= 1'b0;
      err_o      <= 1'b0;
      istat_o    <= '0;
      ien_q      <= '0;
    end else begin
      if (wr_ok && hit(idx, IDX_TIMING))  timing_q   <= wdata_i;
      if (wr_ok && hit(idx, IDX_PTR_LO))  ptr_o      <= wdata_i;
      if (wr_ok && hit(idx, IDX_PTR_HI))  ptr_hi_q   <= wdata_i;
      if (wr_ok && hit(idx, IDX_ADDR_HI)) addr_hi_q  <= wdata_i;
      if (wr_ok && hit(idx, IDX_END))     end_addr_o <= wdata_i;
      if (wr_ok && hit(idx, IDX_IEN))     ien_q      <= ien_q | wdata_i[1:0];
      if (wr_ctrl && !active_i)           dir_o      <= wdata_i[2];
      // stop handshake: held until the walker reports idle
      if (wr_ctrl && wdata_i[1])          stop_o     <= 1'b1;
      else if (!active_i)                 stop_o     <= 1'b0;
      if (err_set_i)                      err_o      <= 1'b1;
      else if (start_o)                   err_o      <= 1'b0;
      // set beats clear
      for (int b = 0; b < 2; b++) begin
        if ((b == 0) ? dev_irq_i : err_set_i)
          istat_o[b] <= 1'b1;
        else if (wr_ok && hit(idx, IDX_ISTAT) && wdata_i[b])
          istat_o[b] <= 1'b0;
      end
    end
  end

  assign irq_o = |(istat_o & ien_q);

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      case (idx)
        IW'(IDX_TIMING):  rdata_o = timing_q;
        IW'(IDX_PTR_LO):  rdata_o = ptr_o;
        IW'(IDX_PTR_HI):  rdata_o = ptr_hi_q;
        IW'(IDX_ADDR_LO): rdata_o = cur_addr_i;
        IW'(IDX_ADDR_HI): rdata_o = addr_hi_q;
        IW'(IDX_DEV_CNT): rdata_o = dev_cnt_i;
        IW'(IDX_MEM_CNT): rdata_o = mem_cnt_i;
        IW'(IDX_CTRL):    rdata_o = {27'd0, err_o, active_i, dir_o, stop_o, 1'b0};
        IW'(IDX_END):     rdata_o = end_addr_o;
        IW'(IDX_ISTAT):   rdata_o = {30'd0, istat_o};
        IW'(IDX_IEN):     rdata_o = {30'd0, ien_q};
        default:          rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/sgdma_walker.sv
module sgdma_walker
  import sgdma_pkg::*;
#(
  parameter int unsigned END_WORDS = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        dir_i,
  input  logic        stop_i,
  input  logic [31:0] ptr_i,
  input  logic [31:0] end_addr_i,
  output logic        active_o,
  output logic        err_set_o,
  output logic [31:0] cur_addr_o,
  output logic [31:0] dev_cnt_o,
  output logic [31:0] mem_cnt_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_rvalid_i,
  input  logic        mem_err_i,
  input  logic [31:0] mem_rdata_i,
  input  logic        dev_rx_valid_i,
  input  logic [7:0]  dev_rx_data_i,
  output logic        dev_rx_ready_o,
  output logic        dev_tx_valid_o,
  output logic [7:0]  dev_tx_data_o,
  input  logic        dev_tx_ready_i
);
  localparam int unsigned MW = (END_WORDS > 1) ? $clog2(END_WORDS) : 1;

  walk_state_e state_q;
  logic [31:0] desc_q, buf_q, word_q;
  logic [16:0] remain_q;
  logic        eol_q;
  logic [1:0]  bidx_q;
  logic [MW-1:0] mark_q;

  logic        rsp_ok;
  logic [15:0] len_w;
  walk_state_e after_desc;

  assign mem_req_o  = (state_q == S_FETCH_A) || (state_q == S_FETCH_L) ||
                      (state_q == S_WR) || (state_q == S_RD) || (state_q == S_MARK);
  assign mem_we_o   = (state_q == S_WR) || (state_q == S_MARK);
  assign rsp_ok     = mem_req_o && mem_rvalid_i && !mem_err_i;
  assign err_set_o  = mem_req_o && mem_rvalid_i && mem_err_i;
  assign len_w      = {mem_rdata_i[15:2], 2'b00};
  assign after_desc = eol_q ? S_MARK : S_FETCH_A;
  assign mem_wdata_o = (state_q == S_MARK) ? '1 : word_q;

  always_comb begin
    case (state_q)
      S_FETCH_A: mem_addr_o = desc_q + 32'd4;
      S_FETCH_L: mem_addr_o = desc_q + 32'd12;
      S_MARK:    mem_addr_o = end_addr_i + {{(30-MW){1'b0}}, mark_q, 2'b00};
      default:   mem_addr_o = buf_q;
    endcase
  end

  assign active_o       = (state_q != S_IDLE);
  assign cur_addr_o     = buf_q;
  assign dev_rx_ready_o = (state_q == S_RX) && !stop_i;
  assign dev_tx_valid_o = (state_q == S_TX) && !stop_i;
  assign dev_tx_data_o  = word_q[bidx_q*8 +: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      desc_q    <= '0;
      buf_q     <= '0;
      word_q    <= '0;
      remain_q  <= '0;
      eol_q     <= 1'b0;
      bidx_q    <= '0;
      mark_q    <= '0;
      dev_cnt_o <= '0;
      mem_cnt_o <= '0;
    end else if (err_set_o) begin
      state_q <= S_IDLE;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          desc_q    <= ptr_i;
          dev_cnt_o <= '0;
          mem_cnt_o <= '0;
          mark_q    <= '0;
          state_q   <= S_FETCH_A;
        end
        S_FETCH_A: if (rsp_ok) begin
          buf_q   <= {mem_rdata_i[31:2], 2'b00};
          state_q <= stop_i ? S_IDLE : S_FETCH_L;
        end
        S_FETCH_L: if (rsp_ok) begin
          remain_q <= {1'b0, len_w};
          eol_q    <= mem_rdata_i[31];
          desc_q   <= desc_q + 32'(DESC_BYTES);
          bidx_q   <= '0;
          if (stop_i)             state_q <= S_IDLE;
          else if (len_w == '0)   state_q <= mem_rdata_i[31] ? S_MARK : S_FETCH_A;
          else                    state_q <= dir_i ? S_RX : S_RD;
        end
        S_RX: if (stop_i) begin
          state_q <= S_IDLE;
        end else if (dev_rx_valid_i) begin
          word_q[bidx_q*8 +: 8] <= dev_rx_data_i;
          dev_cnt_o <= dev_cnt_o + 32'd1;
          bidx_q    <= bidx_q + 2'd1;
          if (bidx_q == 2'd3) state_q <= S_WR;
        end
        S_WR: if (rsp_ok) begin
          mem_cnt_o <= mem_cnt_o + 32'd4;
          buf_q     <= buf_q + 32'd4;
          remain_q  <= remain_q - 17'd4;
          if (stop_i)                  state_q <= S_IDLE;
          else if (remain_q == 17'd4)  state_q <= after_desc;
          else                         state_q <= S_RX;
        end
        S_RD: if (rsp_ok) begin
          word_q    <= mem_rdata_i;
          mem_cnt_o <= mem_cnt_o + 32'd4;
          buf_q     <= buf_q + 32'd4;
          bidx_q    <= '0;
          state_q   <= stop_i ? S_IDLE : S_TX;
        end
        S_TX: if (stop_i) begin
          state_q <= S_IDLE;
        end else if (dev_tx_ready_i) begin
          dev_cnt_o <= dev_cnt_o + 32'd1;
          bidx_q    <= bidx_q + 2'd1;
          if (bidx_q == 2'd3) begin
            remain_q <= remain_q - 17'd4;
            state_q  <= (remain_q == 17'd4) ? after_desc : S_RD;
          end
        end
        S_MARK: if (rsp_ok) begin
          mark_q <= mark_q + 1'b1;
          if (stop_i || mark_q == MW'(END_WORDS - 1)) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine #(
  parameter int unsigned AW        = 6,
  parameter int unsigned END_WORDS = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          irq_o,
  input  logic          dev_irq_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [31:0]   mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_rvalid_i,
  input  logic          mem_err_i,
  input  logic [31:0]   mem_rdata_i,
  input  logic          dev_rx_valid_i,
  input  logic [7:0]    dev_rx_data_i,
  output logic          dev_rx_ready_o,
  output logic          dev_tx_valid_o,
  output logic [7:0]    dev_tx_data_o,
  input  logic          dev_tx_ready_i
);
  logic        start, dir, stop_pend, err_flag, active, err_set;
  logic [1:0]  istat;
  logic [31:0] ptr, end_addr, cur_addr, dev_cnt, mem_cnt;

  sgdma_regs #(.AW(AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .active_i   (active),
    .err_set_i  (err_set),
    .dev_irq_i  (dev_irq_i),
    .cur_addr_i (cur_addr),
    .dev_cnt_i  (dev_cnt),
    .mem_cnt_i  (mem_cnt),
    .start_o    (start),
    .dir_o      (dir),
    .stop_o     (stop_pend),
    .err_o      (err_flag),
    .istat_o    (istat),
    .ptr_o      (ptr),
    .end_addr_o (end_addr),
    .irq_o      (irq_o)
  );

  sgdma_walker #(.END_WORDS(END_WORDS)) u_walk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start),
    .dir_i          (dir),
    .stop_i         (stop_pend),
    .ptr_i          (ptr),
    .end_addr_i     (end_addr),
    .active_o       (active),
    .err_set_o      (err_set),
    .cur_addr_o     (cur_addr),
    .dev_cnt_o      (dev_cnt),
    .mem_cnt_o      (mem_cnt),
    .mem_req_o      (mem_req_o),
    .mem_we_o       (mem_we_o),
    .mem_addr_o     (mem_addr_o),
    .mem_wdata_o    (mem_wdata_o),
    .mem_rvalid_i   (mem_rvalid_i),
    .mem_err_i      (mem_err_i),
    .mem_rdata_i    (mem_rdata_i),
    .dev_rx_valid_i (dev_rx_valid_i),
    .dev_rx_data_i  (dev_rx_data_i),
    .dev_rx_ready_o (dev_rx_ready_o),
    .dev_tx_valid_o (dev_tx_valid_o),
    .dev_tx_data_o  (dev_tx_data_o),
    .dev_tx_ready_i (dev_tx_ready_i)
  );
endmodule

// File: rtl/sgdma_checker.sv
module sgdma_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_wr_i,
  input logic        active,
  input logic        stop_pend,
  input logic        dir,
  input logic        err_flag,
  input logic [1:0]  istat,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_rvalid_i,
  input logic        mem_err_i,
  input logic        dev_rx_ready_o,
  input logic        dev_tx_valid_o
);
  a_r12_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  a_r8_stop_until_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_pend && active |=> stop_pend);

  a_r9_err_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rvalid_i && mem_err_i |=> err_flag && istat[1] && !active);

  a_r3_dir_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active && reg_wr_i |=> $stable(dir));

  a_r5_no_stream_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> !dev_tx_valid_o && !dev_rx_ready_o);
endmodule

bind sg_dma_engine sgdma_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .reg_wr_i       (reg_wr_i),
  .active         (active),
  .stop_pend      (stop_pend),
  .dir            (dir),
  .err_flag       (err_flag),
  .istat          (istat),
  .mem_req_o      (mem_req_o),
  .mem_we_o       (mem_we_o),
  .mem_addr_o     (mem_addr_o),
  .mem_rvalid_i   (mem_rvalid_i),
  .mem_err_i      (mem_err_i),
  .dev_rx_ready_o (dev_rx_ready_o),
  .dev_tx_valid_o (dev_tx_valid_o)
);

// File: tb/sg_dma_engine_tb_top.sv
module sg_dma_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, dev_irq = 1'b0;
  logic        mem_req, mem_we, mem_rvalid, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        rx_valid, rx_ready, tx_valid, tx_ready = 1'b1;
  logic [7:0]  rx_data, tx_data;

  sg_dma_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq), .dev_irq_i(dev_irq),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rvalid_i(mem_rvalid), .mem_err_i(mem_err), .mem_rdata_i(mem_rdata),
    .dev_rx_valid_i(rx_valid), .dev_rx_data_i(rx_data), .dev_rx_ready_o(rx_ready),
    .dev_tx_valid_o(tx_valid), .dev_tx_data_o(tx_data), .dev_tx_ready_i(tx_ready)
  );

  // memory model: one response per request, one cycle later
  logic [31:0] mem [0:1023];
  logic        ld_we = 1'b0;
  logic [31:0] ld_addr = '0, ld_data = '0;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_err    <= 1'b0;
      mem_rdata  <= '0;
      for (int i = 0; i < 1024; i++) mem[i] <= '0;
    end else begin
      if (ld_we) mem[ld_addr[11:2]] <= ld_data;
      if (mem_req && !mem_rvalid) begin
        mem_rvalid <= 1'b1;
        mem_err    <= err_en && (mem_addr == err_addr);
        mem_rdata  <= mem[mem_addr[11:2]];
        if (mem_we && !(err_en && mem_addr == err_addr)) mem[mem_addr[11:2]] <= mem_wdata;
      end else begin
        mem_rvalid <= 1'b0;
        mem_err    <= 1'b0;
      end
    end
  end

  // device source and sink
  logic [7:0] src [0:15];
  int         src_len = 0;
  int         src_idx;
  logic       src_clr = 1'b0;
  logic [7:0] snk [0:15];
  int         snk_n;
  logic       snk_clr = 1'b0;

  assign rx_valid = (src_idx < src_len);
  assign rx_data  = src[src_idx[3:0]];

  always @(posedge clk) begin
    if (!rst_n || src_clr) src_idx <= 0;
    else if (rx_valid && rx_ready) src_idx <= src_idx + 1;
    if (!rst_n || snk_clr) snk_n <= 0;
    else if (tx_valid && tx_ready) begin
      snk[snk_n[3:0]] <= tx_data;
      snk_n <= snk_n + 1;
    end
  end

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 6'(idx * 4); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read_now(input int idx, output logic [31:0] d);
    reg_addr = 6'(idx * 4);
    #1 d = reg_rdata;
  endtask

  task automatic reg_read(input int idx, output logic [31:0] d);
    @(negedge clk);
    reg_read_now(idx, d);
  endtask

  task automatic mem_put(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] p, input logic [31:0] b,
                          input logic [15:0] len, input logic eol);
    mem_put(p + 4, b);
    mem_put(p + 12, {eol, 15'd0, len});
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    for (int i = 0; i < 2000; i++) begin
      reg_read(7, c);
      if (!c[3]) break;
    end
  endtask

  task automatic clear_streams();
    @(negedge clk);
    src_clr = 1'b1; snk_clr = 1'b1;
    @(negedge clk);
    src_clr = 1'b0; snk_clr = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_read(7, d);  chk("R1 ctrl after reset", d, 32'h0);
    reg_read(5, d);  chk("R1 dev count after reset", d, 32'h0);
    reg_read(1, d);  chk("R1 pointer after reset", d, 32'h0);
    reg_read(9, d);  chk("R1 istat after reset", d, 32'h0);
    chk("R11 irq after reset", 32'(irq), 32'h0);
    reg_write(1, 32'h1234_5678);
    reg_read(1, d);  chk("R1 pointer readback", d, 32'h1234_5678);
    reg_addr = 6'h05;
    #1 chk("R1 misaligned read", reg_rdata, 32'h0);
  endtask

  task automatic t_rx_two_desc();
    logic [31:0] d;
    for (int i = 0; i < 12; i++) src[i] = 8'(8'h10 + i);
    clear_streams();
    src_len = 12;
    put_desc(32'h100, 32'h400, 16'd8, 1'b0);
    put_desc(32'h110, 32'h500, 16'd4, 1'b1);
    reg_write(1, 32'h100);
    reg_write(8, 32'h800);
    reg_write(7, 32'h05);
    wait_idle();
    chk("R5 rx word 0", mem[32'h400 >> 2], 32'h1312_1110);
    chk("R5 rx word 1", mem[32'h404 >> 2], 32'h1716_1514);
    chk("R4 rx second desc", mem[32'h500 >> 2], 32'h1B1A_1918);
    reg_read(5, d); chk("R6 dev count rx", d, 32'd12);
    reg_read(6, d); chk("R6 mem count rx", d, 32'd12);
    reg_read(3, d); chk("R1 current address", d, 32'h504);
    reg_read(7, d); chk("R2 ctrl after rx", d, 32'h04);
    chk("R7 marker first", mem[32'h800 >> 2], 32'hFFFF_FFFF);
    chk("R7 marker last", mem[(32'h800 >> 2) + 31], 32'hFFFF_FFFF);
    chk("R7 marker bound", mem[(32'h800 >> 2) + 32], 32'h0);
  endtask

  task automatic t_tx();
    logic [31:0] d;
    clear_streams();
    src_len = 0;
    mem_put(32'h600, 32'h4433_2211);
    mem_put(32'h604, 32'h8877_6655);
    put_desc(32'h120, 32'h600, 16'h000A, 1'b1);
    reg_write(1, 32'h120);
    reg_write(8, 32'h900);
    reg_write(7, 32'h01);
    wait_idle();
    @(negedge clk);
    chk("R4 tx length low bits ignored", 32'(snk_n), 32'd8);
    for (int i = 0; i < 8; i++) chk("R5 tx byte order", 32'(snk[i]), 32'(8'h11 * (i + 1)));
    reg_read(5, d); chk("R6 dev count tx", d, 32'd8);
    reg_read(6, d); chk("R6 mem count tx", d, 32'd8);
    chk("R7 tx marker", mem[32'h900 >> 2], 32'hFFFF_FFFF);
  endtask

  task automatic t_start_ignored_and_stop();
    logic [31:0] d;
    clear_streams();
    tx_ready = 1'b0;
    put_desc(32'h130, 32'h600, 16'd8, 1'b1);
    reg_write(1, 32'h130);
    reg_write(8, 32'hA00);
    reg_write(7, 32'h01);
    repeat (10) @(negedge clk);
    reg_read(7, d); chk("R2 active while stalled", d, 32'h08);
    reg_write(7, 32'h05);
    reg_read_now(7, d); chk("R3 start while active ignored", d, 32'h08);
    reg_write(7, 32'h02);
    reg_read_now(7, d); chk("R8 stop reads one while halting", d, 32'h0A);
    repeat (5) @(negedge clk);
    reg_read(7, d); chk("R8 stop self-clears", d, 32'h00);
    reg_read(5, d); chk("R8 no bytes after stop", d, 32'd0);
    chk("R8 no marker after stop", mem[32'hA00 >> 2], 32'h0);
    tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 no stream after stop", 32'(snk_n), 32'd0);
  endtask

  task automatic t_mem_error();
    logic [31:0] d;
    clear_streams();
    put_desc(32'h140, 32'h700, 16'd4, 1'b1);
    err_addr = 32'h144; err_en = 1'b1;
    reg_write(10, 32'h2);
    reg_write(1, 32'h140);
    reg_write(8, 32'hB00);
    reg_write(7, 32'h01);
    wait_idle();
    reg_read(7, d); chk("R9 error bit", d, 32'h10);
    reg_read(9, d); chk("R9 istat bit1", d, 32'h2);
    chk("R11 irq on enabled error", 32'(irq), 32'h1);
    chk("R9 no marker on error", mem[32'hB00 >> 2], 32'h0);
    err_en = 1'b0;
    reg_write(9, 32'h3);
    reg_read(9, d); chk("R10 w1c clears", d, 32'h0);
    chk("R11 irq drops", 32'(irq), 32'h0);
    reg_write(7, 32'h01);
    wait_idle();
    reg_read(7, d); chk("R9 error cleared by start", d, 32'h00);
  endtask

  task automatic t_irq_collision();
    logic [31:0] d;
    @(negedge clk); dev_irq = 1'b1;
    @(negedge clk); dev_irq = 1'b0;
    reg_read(9, d); chk("R10 device irq sets bit0", d, 32'h1);
    chk("R11 bit0 not enabled", 32'(irq), 32'h0);
    reg_write(10, 32'h1);
    reg_read(10, d); chk("R11 enable only sets", d, 32'h3);
    chk("R11 irq with bit0 enabled", 32'(irq), 32'h1);
    @(negedge clk); dev_irq = 1'b1;
    reg_write(9, 32'h1);
    reg_read_now(9, d); chk("R10 set beats clear", d, 32'h1);
    dev_irq = 1'b0;
    reg_write(9, 32'h1);
    reg_read_now(9, d); chk("R10 clear after set drops", d, 32'h0);
  endtask

  task automatic t_zero_len();
    logic [31:0] d;
    clear_streams();
    put_desc(32'h160, 32'h780, 16'd0, 1'b0);
    put_desc(32'h170, 32'h600, 16'd4, 1'b1);
    reg_write(1, 32'h160);
    reg_write(8, 32'hC00);
    reg_write(7, 32'h01);
    wait_idle();
    @(negedge clk);
    chk("R4 zero length skipped", 32'(snk_n), 32'd4);
    chk("R4 byte after skip", 32'(snk[0]), 32'h11);
    reg_read(6, d); chk("R6 mem count zero desc", d, 32'd4);
    chk("R7 marker after skip", mem[(32'hC00 >> 2) + 31], 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rx_two_desc();
    t_tx();
    t_start_ignored_and_stop();
    t_mem_error();
    t_irq_collision();
    t_zero_len();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule